// File: doc/BRIEF.md
# Radio Baseband Interrupt Aggregator

This block gathers the single-cycle event strobes of a packet radio baseband into sticky status bits and turns them into one level-type interrupt line. It watches three timer comparators, the transmit and receive sequencers, the channel-assessment engine, the address filter and the two-bank receive buffer. Each event owns a status position, and a software register port gives access to those positions. Software enables positions one by one, reads the status, clears bits by writing ones, and picks the polarity of the interrupt line.

Some events need interpretation before they reach a status bit. Two status positions are shared between pairs of events, and a select bit picks which event of each pair drives the position. Frame completion events are held back while an automatic acknowledgement exchange is still due. In that case the completion is reported only when the exchange ends. A receive overrun is detected when reception restarts into a buffer bank whose full flag is still set. The three timer sources fire while the free-running timer equals their compare values.

There are 18 status positions, numbered in a fixed order. Positions 0 to 2 are timer compares 0 to 2. Position 3 is transmit done. Positions 4 and 5 are transmit bank 0 and bank 1 done. Position 6 is the channel-assessment or CSMA-CA completion. Position 7 is receive done. Positions 8 and 9 are receive bank 0 and bank 1 full. Position 10 is start-of-frame, 11 is address match and 12 is overrun. Position 13 is mode-switch frame, 14 is receive level error, 15 is byte count reached and 16 is length received. Position 17 is the per-byte event or the receive timeout.

Top module: `rbb_irq_agg`

## Requirements
- R1: After reset every enable bit, every status bit and every control bit is 0, and `irq_out` is 0.
- R2: A one-cycle event pulse sets its status bit at the next clock edge, and the bit stays 1 after the pulse ends.
- R3: Writing to status registers 3, 4 and 5 (bits 0-7, 8-15 and 16-17) clears each bit written as 1 and leaves bits written as 0 unchanged. An event in the same cycle as the clear wins, so the bit stays 1.
- R4: `irq_out` is registered. It is active one clock after any status bit whose enable bit is 1 becomes 1, and it is inactive while every enabled status bit is 0. Status bits that are not enabled have no effect on `irq_out`.
- R5: Control register 6 bit 0 inverts `irq_out`. At 1 the line idles high and goes low when the interrupt is active.
- R6: Control bit 1 selects the source of position 6: 0 selects CCA completion and 1 selects CSMA-CA completion. The unselected event does not set the bit.
- R7: Control bit 2 selects the source of position 17: 0 selects the per-byte event and 1 selects the receive timeout. The unselected event does not set the bit.
- R8: Transmit done does not set position 3 while automatic ACK-receive mode is on and the frame requested an ACK. In that mode, an ACK received or an ACK wait timeout sets position 3.
- R9: Receive done does not set position 7 while automatic ACK-reply mode is on and the frame requested an ACK. In that mode, the end of the ACK reply sets position 7.
- R10: A receive start into bank b while bank b's full flag is 1 sets position 12, for both banks. A start into a bank whose own flag is 0 does not set it.
- R11: Timer compare k sets position k while the timer value equals compare value k.
- R12: Enable registers 0, 1 and 2 hold positions 0-7, 8-15 and 16-17. Bits above position 17 ignore writes and read as 0, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tmr_val | input | TMR_W | Free-running timer value |
| tmr_cmp0 | input | TMR_W | Compare value 0 |
| tmr_cmp1 | input | TMR_W | Compare value 1 |
| tmr_cmp2 | input | TMR_W | Compare value 2 |
| ev_tx_done | input | 1 | Frame transmission finished |
| tx_ack_req | input | 1 | Sent frame asked for an ACK |
| auto_ack_rx_en | input | 1 | Automatic ACK-receive mode on |
| ev_ack_rcvd | input | 1 | ACK frame received |
| ev_ack_timeout | input | 1 | ACK wait expired |
| ev_tx_bank | input | 2 | Transmit buffer bank drained, one bit per bank |
| ev_cca_done | input | 1 | CCA sequence finished |
| ev_csma_done | input | 1 | CSMA-CA sequence finished |
| ev_rx_done | input | 1 | Frame reception finished |
| rx_ack_req | input | 1 | Received frame asked for an ACK |
| auto_ack_reply_en | input | 1 | Automatic ACK-reply mode on |
| ev_ack_reply_sent | input | 1 | ACK reply transmitted |
| ev_rx_bank_full | input | 2 | Receive bank became full, one bit per bank |
| ev_rx_bank_start | input | 2 | Reception into bank starts, one bit per bank |
| rx_bank_full_flag | input | 2 | Current full flag of each receive bank |
| ev_sfd | input | 1 | Start-of-frame delimiter seen |
| ev_addr_match | input | 1 | Address filter match |
| ev_modesw_rx | input | 1 | Mode-switch frame received |
| ev_level_err | input | 1 | Signal lost during reception |
| ev_byte_cnt | input | 1 | Programmed byte count reached |
| ev_len_rcvd | input | 1 | Length field received |
| ev_rx_byte | input | 1 | One byte received |
| ev_rx_timeout | input | 1 | Automatic receive timeout |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The bench targets these corner cases:
- An event and a write-one-to-clear in the same cycle. A design that lets the clear win loses the interrupt.
- The interrupt line should react one cycle after the status change. A design that drives it directly from status would show the change early. A design with an extra stage would show it late.
- Each shared position is pulsed with the unselected event. A wrong multiplexer sets the bit anyway or drops the selected event.
- Frame completions with ACK requested, with each automatic ACK mode on and off. A missing qualifier reports the frame before the ACK exchange ends, or never reports it.
- An overrun check that mixes one bank's start with the other bank's flag. A design that ORs all flags together would flag an overrun that is false.

// File: rtl/rbb_irq_pkg.sv
package rbb_irq_pkg;
  localparam int NUM_POS     = 18;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 3;
  localparam int NUM_EN_REGS = (NUM_POS + REG_W - 1) / REG_W;
  localparam int NUM_TMR     = 3;

  localparam int A_EN0  = 0;
  localparam int A_ST0  = A_EN0 + NUM_EN_REGS;
  localparam int A_CTRL = A_ST0 + NUM_EN_REGS;

  localparam int P_TX    = 3;
  localparam int P_TXB0  = 4;
  localparam int P_CCA   = 6;
  localparam int P_RX    = 7;
  localparam int P_RXB0  = 8;
  localparam int P_SFD   = 10;
  localparam int P_ADDR  = 11;
  localparam int P_OVR   = 12;
  localparam int P_MODSW = 13;
  localparam int P_LVL   = 14;
  localparam int P_BCNT  = 15;
  localparam int P_LEN   = 16;
  localparam int P_BYTE  = 17;

  typedef struct packed {
    logic sel_timeout;
    logic sel_csma;
    logic pol_low;
  } ctrl_t;
endpackage

// File: rtl/rbb_evt_qualify.sv
module rbb_evt_qualify
  import rbb_irq_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  ctrl_t                           ctrl,
  input  logic [TMR_W-1:0]                tmr_val,
  input  logic [NUM_TMR-1:0][TMR_W-1:0]   tmr_cmp,
  input  logic                            ev_tx_done,
  input  logic                            tx_ack_req,
  input  logic                            auto_ack_rx_en,
  input  logic                            ev_ack_rcvd,
  input  logic                            ev_ack_timeout,
  input  logic [1:0]                      ev_tx_bank,
  input  logic                            ev_cca_done,
  input  logic                            ev_csma_done,
  input  logic                            ev_rx_done,
  input  logic                            rx_ack_req,
  input  logic                            auto_ack_reply_en,
  input  logic                            ev_ack_reply_sent,
  input  logic [1:0]                      ev_rx_bank_full,
  input  logic [1:0]                      ev_rx_bank_start,
  input  logic [1:0]                      rx_bank_full_flag,
  input  logic                            ev_sfd,
  input  logic                            ev_addr_match,
  input  logic                            ev_modesw_rx,
  input  logic                            ev_level_err,
  input  logic                            ev_byte_cnt,
  input  logic                            ev_len_rcvd,
  input  logic                            ev_rx_byte,
  input  logic                            ev_rx_timeout,
  output logic [NUM_POS-1:0]              set_vec
);
  logic [NUM_TMR-1:0] tmr_hit;
  logic tx_hold, rx_hold;

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
    assign tmr_hit[k] = (tmr_val == tmr_cmp[k]);
  end

  assign tx_hold = auto_ack_rx_en & tx_ack_req;
  assign rx_hold = auto_ack_reply_en & rx_ack_req;

  always_comb begin
    set_vec = '0;
    set_vec[NUM_TMR-1:0] = tmr_hit;
    set_vec[P_TX]   = (ev_tx_done & ~tx_hold) |
                      (auto_ack_rx_en & (ev_ack_rcvd | ev_ack_timeout));
    set_vec[P_TXB0 +: 2] = ev_tx_bank;
    set_vec[P_CCA]  = ctrl.sel_csma ? ev_csma_done : ev_cca_done;
    set_vec[P_RX]   = (ev_rx_done & ~rx_hold) |
                      (auto_ack_reply_en & ev_ack_reply_sent);
    set_vec[P_RXB0 +: 2] = ev_rx_bank_full;
    set_vec[P_SFD]  = ev_sfd;
    set_vec[P_ADDR] = ev_addr_match;
    set_vec[P_OVR]  = |(ev_rx_bank_start & rx_bank_full_flag);
    set_vec[P_MODSW] = ev_modesw_rx;
    set_vec[P_LVL]  = ev_level_err;
    set_vec[P_BCNT] = ev_byte_cnt;
    set_vec[P_LEN]  = ev_len_rcvd;
    set_vec[P_BYTE] = ctrl.sel_timeout ? ev_rx_timeout : ev_rx_byte;
  end

  // R8: a held-back transmit completion must not reach the status bank
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_done && auto_ack_rx_en && tx_ack_req && !ev_ack_rcvd && !ev_ack_timeout)
      |-> !set_vec[P_TX]);
  // R9
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_done && auto_ack_reply_en && rx_ack_req && !ev_ack_reply_sent)
      |-> !set_vec[P_RX]);
  // R10
  a_r10_overrun: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_bank_start[1] && rx_bank_full_flag[1]) |-> set_vec[P_OVR]);
  // R6
  a_r6_unselected: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.sel_csma && ev_csma_done && !ev_cca_done) |-> !set_vec[P_CCA]);
  // R11
  a_r11_tmr0: assert property (@(posedge clk) disable iff (rst)
    (tmr_val == tmr_cmp[0]) |-> set_vec[0]);
endmodule

// File: rtl/rbb_status_bank.sv
module rbb_status_bank
  import rbb_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_POS-1:0] set_vec,
  input  logic [NUM_POS-1:0] clr_vec,
  output logic [NUM_POS-1:0] st_q
);
  for (genvar i = 0; i < NUM_POS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)               st_q[i] <= 1'b0;
      else if (set_vec[i])   st_q[i] <= 1'b1;
      else if (clr_vec[i])   st_q[i] <= 1'b0;
    end

    // R2
    a_r2_sticky_set: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> st_q[i]);
    // R3
    a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_vec[i]) |=> !st_q[i]);
    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(st_q[i]));
  end
endmodule

// File: rtl/rbb_irq_drive.sv
module rbb_irq_drive
  import rbb_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_POS-1:0] st,
  input  logic [NUM_POS-1:0] en,
  input  logic               pol_low,
  output logic               irq_q
);
  logic pending;
  assign pending = |(st & en);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pending ^ pol_low;
  end

  // R4 and R5: line follows the masked status one edge later
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (st == '0) |=> (irq_q == $past(pol_low)));
  a_r5_polarity: assert property (@(posedge clk) disable iff (rst)
    (pending && !pol_low) |=> irq_q);
endmodule

// File: rtl/rbb_irq_agg.sv
module rbb_irq_agg
  import rbb_irq_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [TMR_W-1:0]  tmr_val,
  input  logic [TMR_W-1:0]  tmr_cmp0,
  input  logic [TMR_W-1:0]  tmr_cmp1,
  input  logic [TMR_W-1:0]  tmr_cmp2,
  input  logic              ev_tx_done,
  input  logic              tx_ack_req,
  input  logic              auto_ack_rx_en,
  input  logic              ev_ack_rcvd,
  input  logic              ev_ack_timeout,
  input  logic [1:0]        ev_tx_bank,
  input  logic              ev_cca_done,
  input  logic              ev_csma_done,
  input  logic              ev_rx_done,
  input  logic              rx_ack_req,
  input  logic              auto_ack_reply_en,
  input  logic              ev_ack_reply_sent,
  input  logic [1:0]        ev_rx_bank_full,
  input  logic [1:0]        ev_rx_bank_start,
  input  logic [1:0]        rx_bank_full_flag,
  input  logic              ev_sfd,
  input  logic              ev_addr_match,
  input  logic              ev_modesw_rx,
  input  logic              ev_level_err,
  input  logic              ev_byte_cnt,
  input  logic              ev_len_rcvd,
  input  logic              ev_rx_byte,
  input  logic              ev_rx_timeout,
  output logic              irq_out
);
  localparam int LAST_BITS = NUM_POS - (NUM_EN_REGS - 1) * REG_W;
  localparam int A_EN_LAST = A_EN0 + NUM_EN_REGS - 1;

  logic [NUM_POS-1:0] en_q, st_q, set_vec, clr_vec;
  ctrl_t              ctrl_q;
  logic [NUM_TMR-1:0][TMR_W-1:0] cmp_pk;
  int                 addr_i;

  assign addr_i = int'(reg_addr);
  assign cmp_pk = {tmr_cmp2, tmr_cmp1, tmr_cmp0};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NUM_POS; i++)
        if (addr_i == A_EN0 + i / REG_W) en_q[i] <= reg_wdata[i % REG_W];
      if (addr_i == A_CTRL) ctrl_q <= reg_wdata[$bits(ctrl_t)-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_POS; i++)
      clr_vec[i] = reg_wr && (addr_i == A_ST0 + i / REG_W) && reg_wdata[i % REG_W];
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_POS; i++) begin
      if (addr_i == A_EN0 + i / REG_W) reg_rdata[i % REG_W] = en_q[i];
      if (addr_i == A_ST0 + i / REG_W) reg_rdata[i % REG_W] = st_q[i];
    end
    if (addr_i == A_CTRL) reg_rdata[$bits(ctrl_t)-1:0] = ctrl_q;
  end

  rbb_evt_qualify #(.TMR_W(TMR_W)) u_qual (
    .clk(clk), .rst(rst), .ctrl(ctrl_q),
    .tmr_val(tmr_val), .tmr_cmp(cmp_pk),
    .ev_tx_done(ev_tx_done), .tx_ack_req(tx_ack_req),
    .auto_ack_rx_en(auto_ack_rx_en), .ev_ack_rcvd(ev_ack_rcvd),
    .ev_ack_timeout(ev_ack_timeout), .ev_tx_bank(ev_tx_bank),
    .ev_cca_done(ev_cca_done), .ev_csma_done(ev_csma_done),
    .ev_rx_done(ev_rx_done), .rx_ack_req(rx_ack_req),
    .auto_ack_reply_en(auto_ack_reply_en), .ev_ack_reply_sent(ev_ack_reply_sent),
    .ev_rx_bank_full(ev_rx_bank_full), .ev_rx_bank_start(ev_rx_bank_start),
    .rx_bank_full_flag(rx_bank_full_flag), .ev_sfd(ev_sfd),
    .ev_addr_match(ev_addr_match), .ev_modesw_rx(ev_modesw_rx),
    .ev_level_err(ev_level_err), .ev_byte_cnt(ev_byte_cnt),
    .ev_len_rcvd(ev_len_rcvd), .ev_rx_byte(ev_rx_byte),
    .ev_rx_timeout(ev_rx_timeout), .set_vec(set_vec)
  );

  rbb_status_bank u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .st_q(st_q)
  );

  rbb_irq_drive u_drv (
    .clk(clk), .rst(rst), .st(st_q), .en(en_q), .pol_low(ctrl_q.pol_low),
    .irq_q(irq_out)
  );

  // R12: unmapped enable bits in the last register read as zero
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (addr_i == A_EN_LAST) |-> ((reg_rdata >> LAST_BITS) == 8'd0));
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!irq_out && en_q == '0));
endmodule

// File: tb/rbb_irq_agg_bench.sv
module rbb_irq_agg_bench;
  localparam int TW = 16;
  localparam int NV = 21;
  // entry: {event id, expected position, expect set}
  localparam logic [10:0] VEC [NV] = '{
    {5'd0, 5'd0, 1'b1},  {5'd1, 5'd1, 1'b1},  {5'd2, 5'd2, 1'b1},
    {5'd3, 5'd3, 1'b1},  {5'd4, 5'd4, 1'b1},  {5'd5, 5'd5, 1'b1},
    {5'd6, 5'd6, 1'b1},  {5'd7, 5'd6, 1'b0},  {5'd8, 5'd7, 1'b1},
    {5'd9, 5'd8, 1'b1},  {5'd10, 5'd9, 1'b1}, {5'd11, 5'd10, 1'b1},
    {5'd12, 5'd11, 1'b1}, {5'd13, 5'd12, 1'b1}, {5'd14, 5'd13, 1'b1},
    {5'd15, 5'd14, 1'b1}, {5'd16, 5'd15, 1'b1}, {5'd17, 5'd16, 1'b1},
    {5'd18, 5'd17, 1'b1}, {5'd19, 5'd17, 1'b0}, {5'd21, 5'd12, 1'b0}
  };

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [TW-1:0] tmr_val = 0;
  logic [TW-1:0] tmr_cmp0 = 16'd10, tmr_cmp1 = 16'd20, tmr_cmp2 = 16'd30;
  logic ev_tx_done = 0, tx_ack_req = 0, auto_ack_rx_en = 0, ev_ack_rcvd = 0, ev_ack_timeout = 0;
  logic [1:0] ev_tx_bank = 0;
  logic ev_cca_done = 0, ev_csma_done = 0, ev_rx_done = 0, rx_ack_req = 0;
  logic auto_ack_reply_en = 0, ev_ack_reply_sent = 0;
  logic [1:0] ev_rx_bank_full = 0, ev_rx_bank_start = 0, rx_bank_full_flag = 0;
  logic ev_sfd = 0, ev_addr_match = 0, ev_modesw_rx = 0, ev_level_err = 0;
  logic ev_byte_cnt = 0, ev_len_rcvd = 0, ev_rx_byte = 0, ev_rx_timeout = 0;
  logic irq_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rbb_irq_agg #(.TMR_W(TW)) u_rbb_irq_agg (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    reg_addr = a[2:0];
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_st(output logic [17:0] s);
    logic [7:0] b0, b1, b2;
    rd(3, b0); rd(4, b1); rd(5, b2);
    s = {b2[1:0], b1, b0};
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_addr = a[2:0]; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic clr_all();
    wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
  endtask

  task automatic set_ev(input int id, input logic v);
    case (id)
      0: tmr_val = v ? tmr_cmp0 : 16'd0;
      1: tmr_val = v ? tmr_cmp1 : 16'd0;
      2: tmr_val = v ? tmr_cmp2 : 16'd0;
      3: ev_tx_done = v;
      4: ev_tx_bank[0] = v;
      5: ev_tx_bank[1] = v;
      6: ev_cca_done = v;
      7: ev_csma_done = v;
      8: ev_rx_done = v;
      9: ev_rx_bank_full[0] = v;
      10: ev_rx_bank_full[1] = v;
      11: ev_sfd = v;
      12: ev_addr_match = v;
      13: begin ev_rx_bank_start[0] = v; rx_bank_full_flag[0] = v; end
      14: ev_modesw_rx = v;
      15: ev_level_err = v;
      16: ev_byte_cnt = v;
      17: ev_len_rcvd = v;
      18: ev_rx_byte = v;
      19: ev_rx_timeout = v;
      20: ev_ack_rcvd = v;
      21: ev_rx_bank_start[1] = v;
      22: ev_ack_timeout = v;
      23: ev_ack_reply_sent = v;
      24: begin ev_rx_bank_start[1] = v; rx_bank_full_flag[1] = v; end
      25: begin ev_rx_bank_start[0] = v; rx_bank_full_flag[1] = v; end
      default: ;
    endcase
  endtask

  task automatic pulse(input int id);
    set_ev(id, 1'b1);
    @(negedge clk);
    set_ev(id, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [17:0] s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    rd(0, d); chk("R1 en0", d, 0);
    rd(2, d); chk("R1 en2", d, 0);
    rd(6, d); chk("R1 ctrl", d, 0);
    rd_st(s); chk("R1 status", s, 0);
    chk("R1 irq", irq_out, 0);

    // R2 R6 R7 R10 R11: vector table
    for (int v = 0; v < NV; v++) begin
      int id, pos;
      logic e;
      id = int'(VEC[v][10:6]); pos = int'(VEC[v][5:1]); e = VEC[v][0];
      clr_all();
      pulse(id);
      @(negedge clk);
      rd_st(s);
      chk($sformatf("R2 vector %0d", v), s, e ? (18'd1 << pos) : 18'd0);
    end

    // R4: enable position 10, check one-cycle lag
    clr_all();
    wr(1, 8'h04);
    @(negedge clk);
    chk("R4 idle", irq_out, 0);
    pulse(11);
    chk("R4 lag", irq_out, 0);
    @(negedge clk);
    chk("R4 active", irq_out, 1);
    wr(4, 8'h04);
    chk("R4 after clear lag", irq_out, 1);
    @(negedge clk);
    chk("R4 inactive", irq_out, 0);
    pulse(12);
    @(negedge clk);
    chk("R4 disabled no effect", irq_out, 0);
    rd_st(s); chk("R4 disabled bit set", s, 18'h00800);

    // R5: polarity
    clr_all();
    wr(6, 8'h01);
    @(negedge clk);
    chk("R5 idle high", irq_out, 1);
    pulse(11);
    @(negedge clk);
    chk("R5 active low", irq_out, 0);
    wr(6, 8'h00);
    clr_all();
    @(negedge clk);
    chk("R5 back to idle low", irq_out, 0);

    // R3: selective clear and same-cycle priority
    pulse(11); pulse(12);
    wr(4, 8'h04);
    rd_st(s); chk("R3 selective clear", s, 18'h00800);
    reg_addr = 3'd4; reg_wdata = 8'h08; reg_wr = 1; ev_addr_match = 1;
    @(negedge clk);
    reg_wr = 0; ev_addr_match = 0;
    rd_st(s); chk("R3 event wins", s, 18'h00800);
    wr(4, 8'h08);
    rd_st(s); chk("R3 cleared", s, 0);

    // R6: select CSMA-CA
    wr(6, 8'h02);
    pulse(6);
    rd_st(s); chk("R6 cca ignored", s, 0);
    pulse(7);
    rd_st(s); chk("R6 csma sets", s, 18'h00040);
    // R7: select timeout
    clr_all();
    wr(6, 8'h04);
    pulse(18);
    rd_st(s); chk("R7 byte ignored", s, 0);
    pulse(19);
    rd_st(s); chk("R7 timeout sets", s, 18'h20000);
    wr(6, 8'h00);

    // R8: transmit hold-back
    clr_all();
    auto_ack_rx_en = 1; tx_ack_req = 1;
    pulse(3);
    rd_st(s); chk("R8 tx held", s, 0);
    pulse(20);
    rd_st(s); chk("R8 ack rcvd", s, 18'h00008);
    clr_all();
    pulse(22);
    rd_st(s); chk("R8 ack timeout", s, 18'h00008);
    clr_all();
    tx_ack_req = 0;
    pulse(3);
    rd_st(s); chk("R8 no ack req", s, 18'h00008);
    auto_ack_rx_en = 0;

    // R9: receive hold-back
    clr_all();
    auto_ack_reply_en = 1; rx_ack_req = 1;
    pulse(8);
    rd_st(s); chk("R9 rx held", s, 0);
    pulse(23);
    rd_st(s); chk("R9 reply sent", s, 18'h00080);
    auto_ack_reply_en = 0; rx_ack_req = 0;

    // R10: bank 1 overrun and cross-bank case
    clr_all();
    pulse(25);
    rd_st(s); chk("R10 cross bank", s, 0);
    pulse(24);
    rd_st(s); chk("R10 bank1 overrun", s, 18'h01000);

    // R11: compare 2 held for two cycles
    clr_all();
    tmr_val = tmr_cmp2;
    @(negedge clk);
    wr(3, 8'h04);
    tmr_val = 0;
    rd_st(s); chk("R11 match beats clear", s, 18'h00004);

    // R12: unmapped bits
    wr(2, 8'hFF);
    rd(2, d); chk("R12 en2 width", d, 8'h03);
    rd(7, d); chk("R12 unmapped addr", d, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule